// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Generator

This block drives a bank of pulse-width-modulated outputs (ten by default) from a single free-running counter. Every output compares the same counter against a compare value of its own, so all channels share one period and one phase reference. The counter runs in one of two shapes. In edge-aligned mode it climbs from zero to a shared top value and wraps back to zero. In phase-correct mode it climbs to top and then descends to zero, which places every pulse symmetrically around the counter minimum. The live counter value is available on a port for reading.

Software-style configuration arrives as a single-cycle write strobe. The strobe carries the run enable, the mode, two 8-bit rate scalers, the shared top value, and one channel's compare value and polarity. A write that is accepted claims that channel, restarts the counter from zero, and takes effect for a fresh period. A separate release strobe hands a channel back. The top value stays locked while any channel is claimed. The block has no streaming data path, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. Pin routing and clock source selection belong to the surrounding chip.

Top module: `pwm_bank`

## Requirements
- R1: In edge-aligned mode (`cfg_phase`=0) the counter on `count_o` advances by one per step from 0 to top, and the step after top returns it to 0.
- R2: The top value carried by a write is applied only when no channel is claimed. Otherwise the stored top is kept. Once every channel has been released, a new top is accepted again.
- R3: The counter takes one step every (`cfg_div`+1)·(`cfg_pre`+1) clock cycles. `count_o` never exceeds the stored top.
- R4: In phase-correct mode (`cfg_phase`=1) the counter climbs to top, then descends to 0 and turns up again. One full period is 2·top steps, and the counter visits 0 once per period.
- R5: A claimed channel with `cfg_inv`=0 behaves as follows: it is set high at the zero event, it is cleared at the compare match, and `pwm_o[i]` is 1 exactly when the counter is below the compare value. The output shows the counter value of the previous cycle.
- R6: With `cfg_inv`=1 the set and clear actions are swapped, so the output is the complement of the R5 level.
- R7: In phase-correct mode the set and clear actions are exchanged while the counter descends. As a result the R5 level (counter below compare) holds on both slopes, and the pulse is centred on the counter minimum.
- R8: A compare value equal to top keeps a non-inverted output high throughout. A compare value of 0 keeps it low throughout, except when top is 0.
- R9: A write is rejected and changes nothing (the counter keeps running) if its compare value exceeds the effective top, or if `cfg_chan` is not below the channel count.
- R10: An accepted write clears the counter and the rate scalers to 0 and sets the direction to up. The counter then steps only if `cfg_enable` was 1; otherwise it holds at 0.
- R11: An accepted write claims channel `cfg_chan`. `rel_wr` releases channel `rel_chan`. An unclaimed channel drives 0 from the cycle after its release.
- R12: A synchronous active-high `rst` clears the counter, halts it, drives every output to 0, releases all channels and unlocks top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | CHW | Channel addressed by the write |
| cfg_enable | input | 1 | Run the counter after the write |
| cfg_phase | input | 1 | 1 = phase-correct (up/down), 0 = edge-aligned |
| cfg_div | input | 8 | First rate scaler, divides by value+1 |
| cfg_pre | input | 8 | Second rate scaler, divides by value+1 |
| cfg_top | input | CW | Shared top value |
| cfg_cmp | input | CW | Compare value of the addressed channel |
| cfg_inv | input | 1 | Polarity swap of the addressed channel |
| rel_wr | input | 1 | Channel release strobe |
| rel_chan | input | CHW | Channel to release |
| pwm_o | output | N | PWM outputs, bit i is channel i |
| count_o | output | CW | Live shared counter value |

## Verification
An accepted write clears `count_o` at the clock edge that samples the strobe. The first step of the counter follows (`cfg_div`+1)·(`cfg_pre`+1) edges later, and each `pwm_o` bit reflects the counter value one edge after that value appeared. A reference model in the bench updates on every rising edge from the same sampled inputs and pushes the expected counter and output vector into a queue. A monitor pops each entry at the following falling edge, so every comparison sits half a cycle after the edge that produced it. Directed checks measure step intervals, zero-to-zero periods and observed counter maxima in whole cycles on falling edges.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int SCALE_W = 8;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef struct packed {
    logic               run;
    logic               phase;
    logic [SCALE_W-1:0] div;
    logic [SCALE_W-1:0] pre;
  } tbase_cfg_t;

endpackage

// File: rtl/pwm_bank_cfg.sv
module pwm_bank_cfg
  import pwm_bank_pkg::*;
#(
  parameter int N   = 10,
  parameter int CW  = 16,
  parameter int CHW = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [CHW-1:0]            cfg_chan,
  input  logic                      cfg_enable,
  input  logic                      cfg_phase,
  input  logic [SCALE_W-1:0]        cfg_div,
  input  logic [SCALE_W-1:0]        cfg_pre,
  input  logic [CW-1:0]             cfg_top,
  input  logic [CW-1:0]             cfg_cmp,
  input  logic                      cfg_inv,
  input  logic                      rel_wr,
  input  logic [CHW-1:0]            rel_chan,
  output tbase_cfg_t                tcfg_q,
  output logic [CW-1:0]             top_q,
  output logic [N-1:0][CW-1:0]      cmp_q,
  output logic [N-1:0]              inv_q,
  output logic [N-1:0]              act_q,
  output logic                      wr_ok
);

  logic          locked;
  logic [CW-1:0] top_eff;
  logic          chan_ok;
  logic          rel_ok;

  // top is frozen as soon as any channel holds a claim
  assign locked  = |act_q;
  assign top_eff = locked ? top_q : cfg_top;
  assign chan_ok = int'(cfg_chan) < N;
  assign rel_ok  = rel_wr && (int'(rel_chan) < N);
  assign wr_ok   = cfg_wr && chan_ok && (cfg_cmp <= top_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcfg_q <= '0;
      top_q  <= '0;
    end else if (wr_ok) begin
      tcfg_q <= '{run: cfg_enable, phase: cfg_phase, div: cfg_div, pre: cfg_pre};
      top_q  <= top_eff;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic          hit_w;
    logic          hit_r;
    logic [CW-1:0] cmp_r;
    logic          inv_r;
    logic          act_r;

    assign hit_w = wr_ok && (cfg_chan == CHW'(i));
    assign hit_r = rel_ok && (rel_chan == CHW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_r <= '0;
        inv_r <= 1'b0;
        act_r <= 1'b0;
      end else if (hit_w) begin
        cmp_r <= cfg_cmp;
        inv_r <= cfg_inv;
        act_r <= 1'b1;
      end else if (hit_r) begin
        act_r <= 1'b0;
      end
    end

    assign cmp_q[i] = cmp_r;
    assign inv_q[i] = inv_r;
    assign act_q[i] = act_r;
  end

endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  tbase_cfg_t    tcfg,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_q
);

  logic [SCALE_W-1:0] dcnt_q;
  logic [SCALE_W-1:0] pcnt_q;
  dir_e               dir_q;
  logic               div_end;
  logic               pre_end;
  logic [CW-1:0]      cnt_nxt;
  dir_e               dir_nxt;

  assign div_end = (dcnt_q == tcfg.div);
  assign pre_end = (pcnt_q == tcfg.pre);

  // next counter value for one step, per counting shape
  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    if (!tcfg.phase) begin
      cnt_nxt = (cnt_q >= top) ? '0 : cnt_q + 1'b1;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= top) begin
        if (top != '0) begin
          cnt_nxt = cnt_q - 1'b1;
          dir_nxt = DIR_DOWN;
        end
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_nxt = (top != '0) ? CW'(1) : '0;
        dir_nxt = DIR_UP;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dcnt_q <= '0;
      pcnt_q <= '0;
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
    end else if (tcfg.run) begin
      if (div_end) begin
        dcnt_q <= '0;
        if (pre_end) begin
          pcnt_q <= '0;
          cnt_q  <= cnt_nxt;
          dir_q  <= dir_nxt;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] cmp,
  input  logic          inv,
  input  logic          act,
  output logic          pwm_q
);

  logic level;

  // set at zero / clear at match, with the pair exchanged on the down slope,
  // reduces to "below compare"; compare == top never clears
  assign level = (cmp == top) || (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= act && (level ^ inv);
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int N   = 10,
  parameter int CW  = 16,
  localparam int CHW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [CHW-1:0]     cfg_chan,
  input  logic               cfg_enable,
  input  logic               cfg_phase,
  input  logic [SCALE_W-1:0] cfg_div,
  input  logic [SCALE_W-1:0] cfg_pre,
  input  logic [CW-1:0]      cfg_top,
  input  logic [CW-1:0]      cfg_cmp,
  input  logic               cfg_inv,
  input  logic               rel_wr,
  input  logic [CHW-1:0]     rel_chan,
  output logic [N-1:0]       pwm_o,
  output logic [CW-1:0]      count_o
);

  tbase_cfg_t          tcfg_q;
  logic [CW-1:0]       top_cur;
  logic [N-1:0][CW-1:0] cmp_q;
  logic [N-1:0]        inv_q;
  logic [N-1:0]        act_q;
  logic                wr_ok;
  logic                run_q;
  logic                phase_q;

  assign run_q   = tcfg_q.run;
  assign phase_q = tcfg_q.phase;

  pwm_bank_cfg #(.N(N), .CW(CW), .CHW(CHW)) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_chan  (cfg_chan),
    .cfg_enable(cfg_enable),
    .cfg_phase (cfg_phase),
    .cfg_div   (cfg_div),
    .cfg_pre   (cfg_pre),
    .cfg_top   (cfg_top),
    .cfg_cmp   (cfg_cmp),
    .cfg_inv   (cfg_inv),
    .rel_wr    (rel_wr),
    .rel_chan  (rel_chan),
    .tcfg_q    (tcfg_q),
    .top_q     (top_cur),
    .cmp_q     (cmp_q),
    .inv_q     (inv_q),
    .act_q     (act_q),
    .wr_ok     (wr_ok)
  );

  pwm_bank_timebase #(.CW(CW)) i_tbase (
    .clk    (clk),
    .rst    (rst),
    .restart(wr_ok),
    .tcfg   (tcfg_q),
    .top    (top_cur),
    .cnt_q  (count_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    pwm_bank_chan #(.CW(CW)) i_chan (
      .clk  (clk),
      .rst  (rst),
      .cnt  (count_o),
      .top  (top_cur),
      .cmp  (cmp_q[i]),
      .inv  (inv_q[i]),
      .act  (act_q[i]),
      .pwm_q(pwm_o[i])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int N  = 10,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  pwm_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] top_cur,
  input logic [N-1:0]  act_q,
  input logic          wr_ok,
  input logic          run_q,
  input logic          phase_q
);

  // R1
  edge_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !phase_q && !wr_ok && count_o != top_cur)
      |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R1
  edge_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !phase_q && !wr_ok && count_o == top_cur)
      |=> (count_o == top_cur || count_o == '0));

  // R2
  top_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q != '0) |=> $stable(top_cur));

  // R3
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_o <= top_cur);

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (count_o == '0));

  // R10
  halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_ok) |=> $stable(count_o));

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |=> (pwm_o == '0));

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && pwm_o == '0 && act_q == '0));

endmodule

bind pwm_bank pwm_bank_chk #(.N(N), .CW(CW)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .pwm_o  (pwm_o),
  .count_o(count_o),
  .top_cur(top_cur),
  .act_q  (act_q),
  .wr_ok  (wr_ok),
  .run_q  (run_q),
  .phase_q(phase_q)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int N   = 10;
  localparam int CW  = 16;
  localparam int CHW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [CHW-1:0] cfg_chan = '0;
  logic cfg_enable = 1'b0;
  logic cfg_phase = 1'b0;
  logic [7:0] cfg_div = '0;
  logic [7:0] cfg_pre = '0;
  logic [CW-1:0] cfg_top = '0;
  logic [CW-1:0] cfg_cmp = '0;
  logic cfg_inv = 1'b0;
  logic rel_wr = 1'b0;
  logic [CHW-1:0] rel_chan = '0;
  logic [N-1:0] pwm_o;
  logic [CW-1:0] count_o;

  always #2.5 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan),
    .cfg_enable(cfg_enable), .cfg_phase(cfg_phase), .cfg_div(cfg_div),
    .cfg_pre(cfg_pre), .cfg_top(cfg_top), .cfg_cmp(cfg_cmp), .cfg_inv(cfg_inv),
    .rel_wr(rel_wr), .rel_chan(rel_chan), .pwm_o(pwm_o), .count_o(count_o)
  );

  int nchk = 0;
  int nerr = 0;
  string cur_tag = "R12";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  int m_cmp[N];
  bit m_inv[N];
  bit m_act[N];
  int m_top, m_cnt, m_dcnt, m_pcnt, m_div, m_pre;
  bit m_run, m_phase, m_down;
  logic [CW+N-1:0] sb_q[$];

  always @(posedge clk) begin
    logic [N-1:0] o;
    bit locked, acc;
    int teff;
    for (int i = 0; i < N; i++)
      o[i] = m_act[i] && (((m_cmp[i] == m_top) || (m_cnt < m_cmp[i])) ^ m_inv[i]);
    if (rst) begin
      o = '0;
      for (int i = 0; i < N; i++) begin m_cmp[i] = 0; m_inv[i] = 0; m_act[i] = 0; end
      m_top = 0; m_cnt = 0; m_dcnt = 0; m_pcnt = 0; m_div = 0; m_pre = 0;
      m_run = 0; m_phase = 0; m_down = 0;
    end else begin
      locked = 0;
      for (int i = 0; i < N; i++) locked |= m_act[i];
      teff = locked ? m_top : int'(cfg_top);
      acc = cfg_wr && (int'(cfg_chan) < N) && (int'(cfg_cmp) <= teff);
      if (m_run) begin
        if (m_dcnt == m_div) begin
          m_dcnt = 0;
          if (m_pcnt == m_pre) begin
            m_pcnt = 0;
            if (!m_phase) m_cnt = (m_cnt >= m_top) ? 0 : m_cnt + 1;
            else if (!m_down) begin
              if (m_cnt >= m_top) begin
                if (m_top != 0) begin m_cnt--; m_down = 1; end
              end else m_cnt++;
            end else begin
              if (m_cnt == 0) begin m_cnt = (m_top != 0) ? 1 : 0; m_down = 0; end
              else m_cnt--;
            end
          end else m_pcnt++;
        end else m_dcnt++;
      end
      if (acc) begin
        m_top = teff; m_run = cfg_enable; m_phase = cfg_phase;
        m_div = int'(cfg_div); m_pre = int'(cfg_pre);
        m_cmp[cfg_chan] = int'(cfg_cmp); m_inv[cfg_chan] = cfg_inv; m_act[cfg_chan] = 1;
        m_cnt = 0; m_dcnt = 0; m_pcnt = 0; m_down = 0;
      end
      if (rel_wr && int'(rel_chan) < N && !(acc && rel_chan == cfg_chan))
        m_act[rel_chan] = 0;
    end
    sb_q.push_back({CW'(m_cnt), o});
  end

  // monitor: compares half a cycle after each edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [CW+N-1:0] e;
      e = sb_q.pop_front();
      check(count_o == e[CW+N-1:N], {cur_tag, " count"}, int'(count_o), int'(e[CW+N-1:N]));
      check(pwm_o == e[N-1:0], {cur_tag, " pwm"}, int'(pwm_o), int'(e[N-1:0]));
    end
  end

  task automatic cfg(input int ch, input bit en, input bit ph, input int dv, input int pr,
                     input int top, input int cmp, input bit inv);
    @(negedge clk);
    cfg_wr = 1; cfg_chan = CHW'(ch); cfg_enable = en; cfg_phase = ph;
    cfg_div = 8'(dv); cfg_pre = 8'(pr); cfg_top = CW'(top); cfg_cmp = CW'(cmp); cfg_inv = inv;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rel(input int ch);
    @(negedge clk);
    rel_wr = 1; rel_chan = CHW'(ch);
    @(negedge clk);
    rel_wr = 0;
  endtask

  task automatic max_count(input int n, output int mx);
    mx = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (int'(count_o) > mx) mx = int'(count_o);
    end
  endtask

  task automatic high_cycles(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
    end
  endtask

  task automatic zero_period(output int per);
    per = 0;
    while (count_o == 0) @(negedge clk);
    while (count_o != 0) @(negedge clk);
    do begin @(negedge clk); per++; end while (count_o != 0 && per < 1000);
  endtask

  task automatic step_gap(output int gap);
    logic [CW-1:0] c;
    c = count_o;
    while (count_o == c) @(negedge clk);
    c = count_o; gap = 0;
    do begin @(negedge clk); gap++; end while (count_o == c && gap < 1000);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check(count_o == 0, "R12 reset count", int'(count_o), 0);
    check(pwm_o == 0, "R12 reset pwm", int'(pwm_o), 0);
    rst = 0;

    cur_tag = "R1 R5";
    cfg(0, 1, 0, 0, 0, 7, 3, 0);
    max_count(16, v);
    check(v == 7, "R1 max count", v, 7);
    high_cycles(0, 16, v);
    check(v == 6, "R5 ch0 high cycles in 16", v, 6);

    cur_tag = "R8 R6";
    cfg(1, 1, 0, 0, 0, 7, 7, 0);
    cfg(2, 1, 0, 0, 0, 7, 0, 0);
    cfg(3, 1, 0, 0, 0, 7, 2, 1);
    repeat (2) @(negedge clk);
    high_cycles(1, 16, v);
    check(v == 16, "R8 cmp=top always high", v, 16);
    high_cycles(2, 16, v);
    check(v == 0, "R8 cmp=0 always low", v, 0);
    high_cycles(3, 16, v);
    check(v == 12, "R6 inverted ch3 high cycles", v, 12);

    cur_tag = "R2";
    cfg(0, 1, 0, 0, 0, 20, 5, 0);
    max_count(24, v);
    check(v == 7, "R2 top kept while claimed", v, 7);

    cur_tag = "R9";
    cfg(0, 1, 0, 0, 0, 7, 9, 0);
    cfg(12, 1, 0, 0, 0, 7, 1, 0);
    high_cycles(0, 16, v);
    check(v == 10, "R9 ch0 setting kept after rejects", v, 10);

    cur_tag = "R3";
    cfg(0, 1, 0, 2, 1, 7, 5, 0);
    step_gap(v);
    check(v == 6, "R3 cycles per step", v, 6);

    cur_tag = "R4 R7";
    cfg(0, 1, 1, 0, 0, 7, 3, 0);
    zero_period(v);
    check(v == 14, "R4 phase-correct period", v, 14);
    high_cycles(0, 14, v);
    check(v == 5, "R7 centred pulse high cycles", v, 5);

    cur_tag = "R10";
    cfg(0, 0, 0, 0, 0, 7, 3, 0);
    max_count(12, v);
    check(v == 0, "R10 halted counter stays 0", v, 0);

    cur_tag = "R11";
    cfg(0, 1, 0, 0, 0, 7, 3, 0);
    for (int c = 0; c < 4; c++) rel(c);
    repeat (2) @(negedge clk);
    check(pwm_o == 0, "R11 released outputs low", int'(pwm_o), 0);

    cur_tag = "R2 unlock";
    cfg(0, 1, 0, 0, 0, 5, 2, 0);
    max_count(14, v);
    check(v == 5, "R2 new top after release", v, 5);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule